// File: doc/BRIEF.md
# Load/Store Access Checker

This block stands between the execute stage of a processor and its data bus. The stage hands it one load or store at a time. Each request carries an address, an access size, store data, a signed/unsigned flag for loads and a fault flag from an external memory-protection checker. The block first decides whether the access may go out at all. A misaligned or protection-flagged access never reaches the bus. It is answered in the next cycle with the matching exception and a completion pulse. Every other access becomes exactly one bus cycle, with byte enables and store data steered onto the little-endian byte lanes.

When the bus answers, a load result is shifted down from its lanes and sign- or zero-extended. The block then tells the register-file writeback whether the destination may be written. A bus error turns into a load or store access fault, and a faulting load never permits the destination write. For every data exception the trap value output carries the address of the access. The block holds only one access at a time, and it ignores new requests while one is in flight.

Top module: `mem_access_guard`

## Requirements
- R1: Size codes are 0 = byte, 1 = halfword, 2 or 3 = word. A halfword at an odd address, or a word whose address bits [1:0] are not 00, is misaligned. An accepted misaligned load or store raises `exc_ld_misal` or `exc_st_misal` together with `done` in the cycle after acceptance, and starts no bus cycle.
- R2: An accepted request with `req_prot_fault` high that is not misaligned raises `exc_ld_fault` or `exc_st_fault` with `done` in the cycle after acceptance, and starts no bus cycle. When both conditions hold, the misalignment exception is the one reported.
- R3: A request is accepted on a clock edge where `req_valid` is high and `busy` is low. A clean accepted access drives `bus_req` high for exactly the next cycle, with `bus_we` equal to `req_store` and `bus_addr` equal to `req_addr`. Address, direction, enables and data then stay unchanged, and `busy` stays high, until the completing edge. Requests made while `busy` is high are ignored.
- R4: Byte enable bit i is set exactly for lanes addr[1:0] up to addr[1:0]+bytes-1: byte 1<<off, halfword 3<<off, word 4'b1111.
- R5: Store data is replicated across the bus. A byte access puts bits [7:0] on every lane, a halfword puts bits [15:0] on both halves, and a word is passed through unchanged.
- R6: Completion is the first edge with `busy` high and `bus_ack` or `bus_err` high, and `done` is high in the cycle after it. On an ack without error for a load, `rd_we` is high with `done`. `ld_data` then holds `bus_rdata` shifted right by 8*addr[1:0], truncated to the access size, and sign-extended when `req_unsigned` was 0 or zero-extended when it was 1.
- R7: `bus_err` at completion (it wins over a simultaneous `bus_ack`) raises `exc_ld_fault` for a load or `exc_st_fault` for a store, with `rd_we` low.
- R8: Whenever any of the four exception outputs is high, `trap_val` equals the address of the access that caused it.
- R9: At most one exception output is high at a time, each is high only together with `done`, and `rd_we` is never high with an exception.
- R10: After reset `busy`, `bus_req`, `done`, `rd_we` and all exception outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Access request |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_unsigned | input | 1 | Load zero-extends when 1 |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Store data, right-aligned |
| req_prot_fault | input | 1 | Protection checker denies access |
| busy | output | 1 | Access in flight |
| bus_req | output | 1 | One-cycle bus cycle start |
| bus_we | output | 1 | Bus write |
| bus_addr | output | ADDR_W | Bus address |
| bus_be | output | DATA_W/8 | Byte enables |
| bus_wdata | output | DATA_W | Steered store data |
| bus_rdata | input | DATA_W | Read data |
| bus_ack | input | 1 | Transfer done |
| bus_err | input | 1 | Transfer error |
| done | output | 1 | Access finished (one cycle) |
| rd_we | output | 1 | Destination register may be written |
| ld_data | output | 32 | Extended load result |
| exc_ld_misal | output | 1 | Load misaligned |
| exc_st_misal | output | 1 | Store misaligned |
| exc_ld_fault | output | 1 | Load access fault |
| exc_st_fault | output | 1 | Store access fault |
| trap_val | output | ADDR_W | Faulting address |

## Verification
The bench sweeps direction, size, offset, extension flag and protection flag completely. It answers with acks after zero to two wait cycles and injects bus errors along the way. Several kinds of error are targeted. A design with a wrong alignment rule would raise a bus cycle for an odd halfword, or trap a legal byte. Wrong lane steering would show misplaced enables or data, and would return a sign-extended byte where zero extension was asked. A design that let a bus error through to writeback would assert `rd_we` for a faulted load. Requests pushed in while busy expose a block that accepts a second access or lets the bus address drift.

// File: rtl/mag_pkg.sv
package mag_pkg;
   typedef enum logic {
      SEQ_IDLE = 1'b0,
      SEQ_WAIT = 1'b1
   } seq_state_e;

   typedef struct packed {
      logic ld_misal;
      logic st_misal;
      logic ld_fault;
      logic st_fault;
   } exc_vec_t;

   localparam logic [1:0] SZ_BYTE = 2'd0;
   localparam logic [1:0] SZ_HALF = 2'd1;
endpackage

// File: rtl/mag_align.sv
module mag_align #(
   parameter int LANE_BITS = 2
) (
   input  logic [1:0]             size,
   input  logic [LANE_BITS-1:0]   off,
   output logic                   misal,
   output logic [(1<<LANE_BITS)-1:0] be
);
   localparam int NLANE = 1 << LANE_BITS;
   localparam int SUM_W = LANE_BITS + 2;

   logic [SUM_W-1:0] span_lo;
   logic [SUM_W-1:0] span_hi;
   logic [SUM_W-1:0] nbytes;

   // word uses size[1]; halfword is code 1
   assign misal = (size == mag_pkg::SZ_HALF && off[0]) ||
                  (size[1] && off[1:0] != 2'b00);

   assign nbytes  = size[1] ? SUM_W'(4) : (size[0] ? SUM_W'(2) : SUM_W'(1));
   assign span_lo = SUM_W'(off);
   assign span_hi = span_lo + nbytes;

   for (genvar i = 0; i < NLANE; i++) begin : g_be
      assign be[i] = (SUM_W'(i) >= span_lo) && (SUM_W'(i) < span_hi);
   end
endmodule

// File: rtl/mag_lanes.sv
module mag_lanes #(
   parameter int DATA_W    = 32,
   parameter int XLEN      = 32,
   parameter int LANE_BITS = 2
) (
   input  logic [1:0]           st_size,
   input  logic [XLEN-1:0]      st_data,
   output logic [DATA_W-1:0]    st_lanes,
   input  logic [1:0]           ld_size,
   input  logic                 ld_uns,
   input  logic [LANE_BITS-1:0] ld_off,
   input  logic [DATA_W-1:0]    ld_rdata,
   output logic [XLEN-1:0]      ld_value
);
   localparam int NLANE = DATA_W / 8;

   for (genvar i = 0; i < NLANE; i++) begin : g_st
      assign st_lanes[8*i +: 8] = st_size[1] ? st_data[8*(i%4) +: 8] :
                                  st_size[0] ? st_data[8*(i%2) +: 8] :
                                               st_data[7:0];
   end

   logic [DATA_W-1:0] shifted;
   assign shifted = ld_rdata >> {ld_off, 3'b000};

   always_comb begin
      if (ld_size[1]) begin
         ld_value = shifted[XLEN-1:0];
      end else if (ld_size[0]) begin
         ld_value = {{(XLEN-16){~ld_uns & shifted[15]}}, shifted[15:0]};
      end else begin
         ld_value = {{(XLEN-8){~ld_uns & shifted[7]}}, shifted[7:0]};
      end
   end
endmodule

// File: rtl/mag_seq.sv
module mag_seq #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int XLEN   = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   input  logic                  req_store,
   input  logic [1:0]            req_size,
   input  logic                  req_unsigned,
   input  logic [ADDR_W-1:0]     req_addr,
   input  logic                  req_prot_fault,
   input  logic                  misal,
   input  logic [DATA_W/8-1:0]   be_in,
   input  logic [DATA_W-1:0]     wdata_in,
   input  logic                  bus_ack,
   input  logic                  bus_err,
   input  logic [XLEN-1:0]       ld_value,
   output logic                  busy,
   output logic                  bus_req,
   output logic                  bus_we,
   output logic [ADDR_W-1:0]     bus_addr,
   output logic [DATA_W/8-1:0]   bus_be,
   output logic [DATA_W-1:0]     bus_wdata,
   output logic [1:0]            held_size,
   output logic                  held_uns,
   output logic                  done,
   output logic                  rd_we,
   output logic [XLEN-1:0]       ld_data,
   output mag_pkg::exc_vec_t     exc,
   output logic [ADDR_W-1:0]     trap_val
);
   import mag_pkg::*;

   seq_state_e state;
   logic       reject;

   assign reject = misal | req_prot_fault;
   assign busy   = (state == SEQ_WAIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= SEQ_IDLE;
         bus_req   <= 1'b0;
         bus_we    <= 1'b0;
         bus_addr  <= '0;
         bus_be    <= '0;
         bus_wdata <= '0;
         held_size <= '0;
         held_uns  <= 1'b0;
         done      <= 1'b0;
         rd_we     <= 1'b0;
         ld_data   <= '0;
         exc       <= '0;
         trap_val  <= '0;
      end else begin
         bus_req <= 1'b0;
         done    <= 1'b0;
         rd_we   <= 1'b0;
         exc     <= '0;
         case (state)
            SEQ_IDLE: begin
               if (req_valid) begin
                  if (reject) begin
                     done         <= 1'b1;
                     trap_val     <= req_addr;
                     exc.ld_misal <= misal & ~req_store;
                     exc.st_misal <= misal &  req_store;
                     exc.ld_fault <= ~misal & ~req_store;
                     exc.st_fault <= ~misal &  req_store;
                  end else begin
                     state     <= SEQ_WAIT;
                     bus_req   <= 1'b1;
                     bus_we    <= req_store;
                     bus_addr  <= req_addr;
                     bus_be    <= be_in;
                     bus_wdata <= wdata_in;
                     held_size <= req_size;
                     held_uns  <= req_unsigned;
                  end
               end
            end
            SEQ_WAIT: begin
               if (bus_ack || bus_err) begin
                  state <= SEQ_IDLE;
                  done  <= 1'b1;
                  if (bus_err) begin
                     exc.ld_fault <= ~bus_we;
                     exc.st_fault <=  bus_we;
                     trap_val     <= bus_addr;
                  end else if (!bus_we) begin
                     rd_we   <= 1'b1;
                     ld_data <= ld_value;
                  end
               end
            end
            default: state <= SEQ_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/mem_access_guard.sv
module mem_access_guard #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic                req_store,
   input  logic [1:0]          req_size,
   input  logic                req_unsigned,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic [31:0]         req_wdata,
   input  logic                req_prot_fault,
   output logic                busy,
   output logic                bus_req,
   output logic                bus_we,
   output logic [ADDR_W-1:0]   bus_addr,
   output logic [DATA_W/8-1:0] bus_be,
   output logic [DATA_W-1:0]   bus_wdata,
   input  logic [DATA_W-1:0]   bus_rdata,
   input  logic                bus_ack,
   input  logic                bus_err,
   output logic                done,
   output logic                rd_we,
   output logic [31:0]         ld_data,
   output logic                exc_ld_misal,
   output logic                exc_st_misal,
   output logic                exc_ld_fault,
   output logic                exc_st_fault,
   output logic [ADDR_W-1:0]   trap_val
);
   localparam int XLEN      = 32;
   localparam int NLANE     = DATA_W / 8;
   localparam int LANE_BITS = $clog2(NLANE);

   if (DATA_W != 32 && DATA_W != 64) begin : g_bad_width
      $error("mem_access_guard: DATA_W must be 32 or 64");
   end
   if (ADDR_W <= LANE_BITS + 1) begin : g_bad_addr
      $error("mem_access_guard: ADDR_W too small for the lane count");
   end

   logic                 misal;
   logic [NLANE-1:0]     be_req;
   logic [DATA_W-1:0]    wdata_lanes;
   logic [1:0]           held_size;
   logic                 held_uns;
   logic [XLEN-1:0]      ld_value;
   mag_pkg::exc_vec_t    exc;

   mag_align #(.LANE_BITS(LANE_BITS)) u_align (
      .size  (req_size),
      .off   (req_addr[LANE_BITS-1:0]),
      .misal (misal),
      .be    (be_req)
   );

   mag_lanes #(.DATA_W(DATA_W), .XLEN(XLEN), .LANE_BITS(LANE_BITS)) u_lanes (
      .st_size  (req_size),
      .st_data  (req_wdata),
      .st_lanes (wdata_lanes),
      .ld_size  (held_size),
      .ld_uns   (held_uns),
      .ld_off   (bus_addr[LANE_BITS-1:0]),
      .ld_rdata (bus_rdata),
      .ld_value (ld_value)
   );

   mag_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .XLEN(XLEN)) u_seq (
      .clk            (clk),
      .rst_n          (rst_n),
      .req_valid      (req_valid),
      .req_store      (req_store),
      .req_size       (req_size),
      .req_unsigned   (req_unsigned),
      .req_addr       (req_addr),
      .req_prot_fault (req_prot_fault),
      .misal          (misal),
      .be_in          (be_req),
      .wdata_in       (wdata_lanes),
      .bus_ack        (bus_ack),
      .bus_err        (bus_err),
      .ld_value       (ld_value),
      .busy           (busy),
      .bus_req        (bus_req),
      .bus_we         (bus_we),
      .bus_addr       (bus_addr),
      .bus_be         (bus_be),
      .bus_wdata      (bus_wdata),
      .held_size      (held_size),
      .held_uns       (held_uns),
      .done           (done),
      .rd_we          (rd_we),
      .ld_data        (ld_data),
      .exc            (exc),
      .trap_val       (trap_val)
   );

   assign exc_ld_misal = exc.ld_misal;
   assign exc_st_misal = exc.st_misal;
   assign exc_ld_fault = exc.ld_fault;
   assign exc_st_fault = exc.st_fault;
endmodule

// File: rtl/mem_access_guard_chk.sv
module mem_access_guard_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_store,
   input logic [1:0]        req_size,
   input logic [ADDR_W-1:0] req_addr,
   input logic              req_prot_fault,
   input logic              busy,
   input logic              bus_req,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_ack,
   input logic              bus_err,
   input logic              done,
   input logic              rd_we,
   input logic              exc_ld_misal,
   input logic              exc_st_misal,
   input logic              exc_ld_fault,
   input logic              exc_st_fault,
   input logic [ADDR_W-1:0] trap_val
);
   logic odd_access;
   logic any_exc;
   assign odd_access = (req_size == 2'd1 && req_addr[0]) ||
                       (req_size[1] && req_addr[1:0] != 2'b00);
   assign any_exc = exc_ld_misal | exc_st_misal | exc_ld_fault | exc_st_fault;

   assert_misal_no_bus_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !busy && odd_access) |=>
         (!bus_req && done && (req_store ? 1'b1 : 1'b1) && (exc_ld_misal || exc_st_misal)));

   assert_prot_no_bus_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !busy && req_prot_fault) |=> (!bus_req && done && any_exc));

   assert_req_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |=> !bus_req);

   assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(bus_addr) && $stable(bus_we)));

   assert_rdwe_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_we |-> (done && !any_exc));

   assert_err_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && bus_err && bus_we) |=> exc_st_fault);

   assert_err_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && bus_err && !bus_we) |=> (exc_ld_fault && !rd_we));

   assert_trap_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && bus_err) |=> (trap_val == $past(bus_addr)));

   assert_exc_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({exc_ld_misal, exc_st_misal, exc_ld_fault, exc_st_fault}));

   assert_exc_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      any_exc |-> done);

   // completion signals are meaningful only while busy
   logic unused_ack;
   assign unused_ack = bus_ack;
endmodule

bind mem_access_guard mem_access_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .req_valid      (req_valid),
   .req_store      (req_store),
   .req_size       (req_size),
   .req_addr       (req_addr),
   .req_prot_fault (req_prot_fault),
   .busy           (busy),
   .bus_req        (bus_req),
   .bus_we         (bus_we),
   .bus_addr       (bus_addr),
   .bus_ack        (bus_ack),
   .bus_err        (bus_err),
   .done           (done),
   .rd_we          (rd_we),
   .exc_ld_misal   (exc_ld_misal),
   .exc_st_misal   (exc_st_misal),
   .exc_ld_fault   (exc_ld_fault),
   .exc_st_fault   (exc_st_fault),
   .trap_val       (trap_val)
);

// File: tb/tb_mem_access_guard.sv
`timescale 1ns/1ps
module tb_mem_access_guard;
   localparam int ADDR_W = 32;
   localparam int DATA_W = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_store = 1'b0;
   logic [1:0]  req_size = '0;
   logic        req_unsigned = 1'b0;
   logic [31:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic        req_prot_fault = 1'b0;
   logic        busy;
   logic        bus_req;
   logic        bus_we;
   logic [31:0] bus_addr;
   logic [3:0]  bus_be;
   logic [31:0] bus_wdata;
   logic [31:0] bus_rdata = '0;
   logic        bus_ack = 1'b0;
   logic        bus_err = 1'b0;
   logic        done;
   logic        rd_we;
   logic [31:0] ld_data;
   logic        exc_ld_misal, exc_st_misal, exc_ld_fault, exc_st_fault;
   logic [31:0] trap_val;

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   mem_access_guard #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (.*);

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 100000 && !finished) begin
         failures++;
         $display("FAIL R3 watchdog actual=%0d expected=done", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic run_acc(input logic st, input logic [1:0] sz, input logic [31:0] addr,
                          input logic uns, input logic prot, input logic [31:0] wd,
                          input logic [31:0] rd, input int lat, input logic err,
                          input logic intrude);
      int off;
      bit mis;
      logic [31:0] exp_be, exp_wd, exp_ld, v;
      logic [3:0] exp_exc;
      off = int'(addr[1:0]);
      mis = (sz == 2'd1 && addr[0]) || (sz[1] && addr[1:0] != 2'b00);
      exp_be = sz[1] ? 32'hF : (sz[0] ? (32'h3 << off) : (32'h1 << off));
      exp_wd = sz[1] ? wd : (sz[0] ? {2{wd[15:0]}} : {4{wd[7:0]}});
      v = rd >> (8 * off);
      if (sz[1]) exp_ld = v;
      else if (sz[0]) exp_ld = (!uns && v[15]) ? (v & 32'hFFFF) | 32'hFFFF0000 : v & 32'hFFFF;
      else exp_ld = (!uns && v[7]) ? (v & 32'hFF) | 32'hFFFFFF00 : v & 32'hFF;

      @(negedge clk);
      req_valid = 1; req_store = st; req_size = sz; req_addr = addr;
      req_unsigned = uns; req_prot_fault = prot; req_wdata = wd;
      @(negedge clk);
      req_valid = 0;
      if (mis || prot) begin
         // {ld_misal, st_misal, ld_fault, st_fault}
         exp_exc = mis ? (st ? 4'b0100 : 4'b1000) : (st ? 4'b0001 : 4'b0010);
         chk(mis ? "R1 no bus cycle" : "R2 no bus cycle", bus_req, 0);
         chk(mis ? "R1 done" : "R2 done", done, 1);
         chk(mis ? "R1 exception kind" : "R2 exception kind",
             {exc_ld_misal, exc_st_misal, exc_ld_fault, exc_st_fault}, exp_exc);
         chk("R8 trap value", trap_val, addr);
         chk("R9 no writeback on exception", rd_we, 0);
         return;
      end
      chk("R3 bus_req pulse", bus_req, 1);
      chk("R3 bus_addr", bus_addr, addr);
      chk("R3 bus_we", bus_we, st);
      chk("R4 byte enables", bus_be, exp_be);
      if (st) chk("R5 store lanes", bus_wdata, exp_wd);
      if (intrude) begin
         req_valid = 1; req_addr = addr ^ 32'h0000_0F00; req_store = ~st;
      end
      for (int k = 0; k < lat; k++) begin
         @(negedge clk);
         chk("R3 single pulse", bus_req, 0);
         chk("R3 busy held", busy, 1);
         chk("R3 addr held", bus_addr, addr);
      end
      bus_ack = !err; bus_err = err; bus_rdata = rd; req_valid = 0;
      @(negedge clk);
      bus_ack = 0; bus_err = 0;
      chk("R6 done after completion", done, 1);
      chk("R3 busy released", busy, 0);
      if (err) begin
         chk("R7 fault kind", {exc_ld_misal, exc_st_misal, exc_ld_fault, exc_st_fault},
             st ? 4'b0001 : 4'b0010);
         chk("R7 no writeback", rd_we, 0);
         chk("R8 trap value bus error", trap_val, addr);
      end else begin
         chk("R9 no exception", {exc_ld_misal, exc_st_misal, exc_ld_fault, exc_st_fault}, 0);
         chk("R6 writeback enable", rd_we, !st);
         if (!st) chk("R6 load data", ld_data, exp_ld);
      end
      @(negedge clk);
      chk("R3 ignored request gave no bus cycle", bus_req, 0);
      chk("R9 done is one cycle", done, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R10 busy reset", busy, 0);
      chk("R10 bus_req reset", bus_req, 0);
      chk("R10 done reset", done, 0);
      chk("R10 rd_we reset", rd_we, 0);
      chk("R10 exc reset", {exc_ld_misal, exc_st_misal, exc_ld_fault, exc_st_fault}, 0);
      rst_n = 1;
      for (int st = 0; st < 2; st++)
         for (int sz = 0; sz < 4; sz++)
            for (int off = 0; off < 4; off++)
               for (int uns = 0; uns < 2; uns++)
                  for (int pr = 0; pr < 2; pr++) begin
                     int idx;
                     logic [31:0] a, wd, rd;
                     idx = (((st * 4 + sz) * 4 + off) * 2 + uns) * 2 + pr;
                     a  = 32'h2000_0000 + (idx << 4) + off;
                     wd = 32'hA1B2C3D4 ^ (idx * 32'h01030507);
                     rd = (idx[1] ? 32'h8CF1_7E93 : 32'h7A0E_F16C) ^ (idx * 32'h00110011);
                     run_acc(st[0], sz[1:0], a, uns[0], pr[0], wd, rd,
                             idx % 3, (idx % 5) == 4, (idx % 2) == 1);
                  end
      // both ack and err: error wins
      @(negedge clk);
      req_valid = 1; req_store = 0; req_size = 2'd2; req_addr = 32'h3000_0040;
      req_prot_fault = 0;
      @(negedge clk);
      req_valid = 0; bus_ack = 1; bus_err = 1;
      @(negedge clk);
      bus_ack = 0; bus_err = 0;
      chk("R7 error beats ack", exc_ld_fault, 1);
      chk("R7 error beats ack writeback", rd_we, 0);
      repeat (2) @(negedge clk);
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule